// File: doc/BRIEF.md
# Grouped Interrupt Merger with Programmable Pin

This block collects interrupt activity from two sub-groups (a 32-bit endpoint group and a DMA-completion group) and from direct event inputs, and folds everything into one 32-bit top-level pending word. That word drives a single interrupt pin. Each of the three groups has a pending register that software changes only through write-one-to-set and write-one-to-clear addresses, plus a mask register. In the endpoint group the low half of the word holds transmit endpoints and the high half holds receive endpoints. Each half contributes its own summary bit to the top-level word. Any unmasked DMA bit raises a third summary bit.

The pin is registered. Its sense is chosen by a configuration bit: it is either asserted while something is pending or asserted while nothing is pending. After the power input rises, a gate holds the pin low for a parameterised number of clock cycles. The gate opens only if power stays on for that whole interval.

Top module: `irq_merge_ctrl`

## Requirements
- R1: In each group (top, endpoint, DMA), a write to the set address ORs the write data into the pending word, and a write to the clear address clears every pending bit written as one. Both take effect at the clock edge of the write. A write to the source address is ignored.
- R2: The bus address is decoded as group in bits 3:2 (0 top, 1 endpoint, 2 DMA, 3 configuration) and function in bits 1:0 (0 source, 1 set, 2 clear, 3 mask). Reads of the source, set and clear addresses return the group's pending word, and a read of the mask address returns its mask. Address 12 reads and writes the configuration word. Every other configuration-group address reads zero.
- R3: After reset the top-level mask is all ones and the top-level pending word is zero. The endpoint and DMA pending words and masks, the configuration word and the pin are all zero.
- R4: Top-level bit 9 is one exactly when some endpoint bit in 15:0 is pending and unmasked. Bit 8 follows the same rule for endpoint bits 31:16. Both bits lag the endpoint state by one cycle, and bus writes to bits 9 and 8 have no effect.
- R5: Top-level bit 24 is one exactly when some DMA bit is pending and unmasked. It lags the DMA state by one cycle, and bus writes to bit 24 have no effect.
- R6: With configuration bit 17 set and the gate open, the pin is the OR of (top pending AND NOT top mask), taken one cycle after that state.
- R7: With configuration bit 17 clear and the gate open, the pin is one only when no top-level bit is both pending and unmasked, again with a one-cycle lag.
- R8: The gate is closed at reset. A rising edge on the power input closes the gate, and the pin is low in every cycle after a cycle in which the gate was closed. When power is sampled high at edge E, the gate opens at edge E+PWR_WAIT_CYC.
- R9: If power falls while the gate is waiting, the wait is abandoned and the gate stays closed until a later rising edge of power and a full new interval.
- R10: A change on event input i (i below EVT_N, at most 8) makes top-level bit i equal to the new input level at the next edge. In that same cycle this takes priority over a bus write to the bit.
- R11: Any change of the VBUS-valid input sets top-level bit 15, and any change of the ID input sets bit 14. Both bits stay set until cleared by a bus write, and the input change wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address (group, function) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_evt | input | EVT_N | Level event inputs from the USB core |
| vbus_valid | input | 1 | VBUS-valid status from the PHY |
| id_status | input | 1 | ID-pin status from the PHY |
| power_on | input | 1 | Power-good input |
| irq_pin | output | 1 | Interrupt output |

## Verification
The bench builds the block with PWR_WAIT_CYC set to 20 instead of the half-second default. This makes the end of the power-up wait, and a power drop in the middle of that wait, reachable within a few dozen cycles, so the exact opening edge of the gate can be compared cycle by cycle. EVT_N stays at 8, so every event bit up to the one just below the RX summary can be exercised. The tests include an event change and a bus clear that land on the same bit in the same cycle.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ADDR_W   = 4;
    // group code in address bits 3:2
    localparam logic [1:0] GRP_TOP   = 2'd0;
    localparam logic [1:0] GRP_EP    = 2'd1;
    localparam logic [1:0] GRP_DMA   = 2'd2;
    localparam logic [1:0] GRP_CFG   = 2'd3;
    // function code in address bits 1:0
    localparam logic [1:0] FN_SRC    = 2'd0;
    localparam logic [1:0] FN_SET    = 2'd1;
    localparam logic [1:0] FN_CLR    = 2'd2;
    localparam logic [1:0] FN_MASK   = 2'd3;
    // top-level bit positions
    localparam int unsigned BIT_RX   = 8;
    localparam int unsigned BIT_TX   = 9;
    localparam int unsigned BIT_ID   = 14;
    localparam int unsigned BIT_VBUS = 15;
    localparam int unsigned BIT_DMA  = 24;
    localparam int unsigned CFG_POL  = 17;
    localparam int unsigned HALF_W   = WORD_W / 2;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] mask;
    } grp_state_t;
endpackage

// File: rtl/irq_reg_group.sv
module irq_reg_group
    import irq_merge_pkg::*;
#(
    parameter logic [WORD_W-1:0] MASK_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_mask,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] src_o,
    output logic [WORD_W-1:0] mask_o
);
    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_set)  st_d.src  = st_q.src | wdata;
        if (wr_clr)  st_d.src  = st_q.src & ~wdata;
        if (wr_mask) st_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.src  <= '0;
            st_q.mask <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_o  = st_q.src;
    assign mask_o = st_q.mask;

    assert_set_or_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((src_o & $past(wdata)) == $past(wdata)));
    assert_clr_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((src_o & $past(wdata)) == '0));
endmodule

// File: rtl/irq_power_gate.sv
module irq_power_gate #(
    parameter int unsigned WAIT_CYC = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_on,
    output logic gate_open
);
    localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        logic             pwr;
        logic             run;
        logic             open;
        logic [CNT_W-1:0] cnt;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwr = power_on;
        if (power_on && !st_q.pwr) begin
            st_d.open = 1'b0;
            st_d.run  = 1'b1;
            st_d.cnt  = CNT_W'(WAIT_CYC);
        end else if (st_q.run) begin
            if (!power_on) begin
                st_d.run = 1'b0;
            end else if (st_q.cnt == CNT_W'(1)) begin
                st_d.open = 1'b1;
                st_d.run  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_open = st_q.open;

    assert_rise_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_on) |=> !gate_open);
    assert_no_open_unpowered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_on && !gate_open) |=> !gate_open);
endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
    import irq_merge_pkg::*;
#(
    parameter int unsigned EVT_N        = 8,
    parameter int unsigned PWR_WAIT_CYC = 30_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [EVT_N-1:0]  core_evt,
    input  logic              vbus_valid,
    input  logic              id_status,
    input  logic              power_on,
    output logic              irq_pin
);
    localparam int unsigned SUB_N = 2;

    typedef struct packed {
        logic [WORD_W-1:0] top_src;
        logic [WORD_W-1:0] top_mask;
        logic [WORD_W-1:0] cfg;
        logic [EVT_N-1:0]  evt;
        logic              vbus;
        logic              id;
        logic              pin;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [1:0]        dec_grp, dec_fn;
    logic [WORD_W-1:0] sub_src  [SUB_N];
    logic [WORD_W-1:0] sub_mask [SUB_N];
    logic [WORD_W-1:0] ep_live, dma_live, top_live;
    logic              tx_any, rx_any, dma_any, gate_open;

    assign dec_grp = bus_addr[3:2];
    assign dec_fn  = bus_addr[1:0];

    // endpoint group (index 0) and DMA group (index 1)
    for (genvar g = 0; g < SUB_N; g++) begin : g_sub
        localparam logic [1:0] GCODE = (g == 0) ? GRP_EP : GRP_DMA;
        logic hit;
        assign hit = bus_wr && (dec_grp == GCODE);
        irq_reg_group #(.MASK_RST('0)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_set  (hit && dec_fn == FN_SET),
            .wr_clr  (hit && dec_fn == FN_CLR),
            .wr_mask (hit && dec_fn == FN_MASK),
            .wdata   (bus_wdata),
            .src_o   (sub_src[g]),
            .mask_o  (sub_mask[g])
        );
    end

    irq_power_gate #(.WAIT_CYC(PWR_WAIT_CYC)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .power_on  (power_on),
        .gate_open (gate_open)
    );

    assign ep_live  = sub_src[0] & ~sub_mask[0];
    assign dma_live = sub_src[1] & ~sub_mask[1];
    assign tx_any   = |ep_live[HALF_W-1:0];
    assign rx_any   = |ep_live[WORD_W-1:HALF_W];
    assign dma_any  = |dma_live;
    assign top_live = st_q.top_src & ~st_q.top_mask;

    always_comb begin
        st_d = st_q;
        if (bus_wr && dec_grp == GRP_TOP) begin
            case (dec_fn)
                FN_SET:  st_d.top_src  = st_q.top_src | bus_wdata;
                FN_CLR:  st_d.top_src  = st_q.top_src & ~bus_wdata;
                FN_MASK: st_d.top_mask = bus_wdata;
                default: ;
            endcase
        end
        if (bus_wr && dec_grp == GRP_CFG && dec_fn == 2'd0)
            st_d.cfg = bus_wdata;
        // event inputs override bus writes on the same bit
        for (int i = 0; i < int'(EVT_N); i++) begin
            if (core_evt[i] != st_q.evt[i]) st_d.top_src[i] = core_evt[i];
        end
        if (vbus_valid != st_q.vbus) st_d.top_src[BIT_VBUS] = 1'b1;
        if (id_status  != st_q.id)   st_d.top_src[BIT_ID]   = 1'b1;
        st_d.evt  = core_evt;
        st_d.vbus = vbus_valid;
        st_d.id   = id_status;
        // summary bits follow the sub-groups
        st_d.top_src[BIT_TX]  = tx_any;
        st_d.top_src[BIT_RX]  = rx_any;
        st_d.top_src[BIT_DMA] = dma_any;
        // registered pin
        if (!gate_open)               st_d.pin = 1'b0;
        else if (st_q.cfg[CFG_POL])   st_d.pin = |top_live;
        else                          st_d.pin = ~|top_live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.top_mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (dec_grp)
            GRP_TOP: bus_rdata = (dec_fn == FN_MASK) ? st_q.top_mask : st_q.top_src;
            GRP_EP:  bus_rdata = (dec_fn == FN_MASK) ? sub_mask[0] : sub_src[0];
            GRP_DMA: bus_rdata = (dec_fn == FN_MASK) ? sub_mask[1] : sub_src[1];
            default: bus_rdata = (dec_fn == 2'd0) ? st_q.cfg : '0;
        endcase
    end

    assign irq_pin = st_q.pin;

    assert_tx_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.top_src[BIT_TX] == $past(tx_any));
    assert_rx_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.top_src[BIT_RX] == $past(rx_any));
    assert_dma_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.top_src[BIT_DMA] == $past(dma_any));
    assert_pin_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> !irq_pin);
    assert_evt_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_evt[0] != st_q.evt[0]) |=> (st_q.top_src[0] == $past(core_evt[0])));
    assert_vbus_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (vbus_valid != st_q.vbus) |=> st_q.top_src[BIT_VBUS]);
endmodule

// File: tb/irq_merge_ctrl_test.sv
`timescale 1ns/1ps
module irq_merge_ctrl_test;
    localparam int EVT_N = 8;
    localparam int WAIT  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [EVT_N-1:0] core_evt = '0;
    logic        vbus_valid = 1'b0;
    logic        id_status = 1'b0;
    logic        power_on = 1'b0;
    logic        irq_pin;

    always #2.5 clk = ~clk;

    irq_merge_ctrl #(.EVT_N(EVT_N), .PWR_WAIT_CYC(WAIT)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_evt(core_evt),
        .vbus_valid(vbus_valid), .id_status(id_status), .power_on(power_on),
        .irq_pin(irq_pin)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_en = 0;
    string phase = "R3";

    // behavioural reference
    logic [31:0] m_src [3];
    logic [31:0] m_msk [3];
    logic [31:0] m_cfg;
    logic [EVT_N-1:0] m_evt;
    logic m_vb, m_id, m_pin, m_gate, m_run, m_pwr;
    int   m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_src[k]) begin m_src[k] = 0; m_msk[k] = 0; end
            m_msk[0] = 32'hFFFF_FFFF;
            m_cfg = 0; m_evt = 0; m_vb = 0; m_id = 0; m_pin = 0;
            m_gate = 0; m_run = 0; m_pwr = 0; m_cnt = 0;
        end else begin
            logic [31:0] ep_l, dma_l, top_l, nt;
            logic npin;
            int g, f;
            ep_l  = m_src[1] & ~m_msk[1];
            dma_l = m_src[2] & ~m_msk[2];
            top_l = m_src[0] & ~m_msk[0];
            npin  = !m_gate ? 1'b0 : (m_cfg[17] ? (top_l != 0) : (top_l == 0));
            nt = m_src[0];
            g = int'(bus_addr[3:2]); f = int'(bus_addr[1:0]);
            if (bus_wr) begin
                if (g == 0 && f == 1) nt = nt | bus_wdata;
                if (g == 0 && f == 2) nt = nt & ~bus_wdata;
                if (g == 0 && f == 3) m_msk[0] = bus_wdata;
                if (g == 1 || g == 2) begin
                    if (f == 1) m_src[g] = m_src[g] | bus_wdata;
                    if (f == 2) m_src[g] = m_src[g] & ~bus_wdata;
                    if (f == 3) m_msk[g] = bus_wdata;
                end
                if (g == 3 && f == 0) m_cfg = bus_wdata;
            end
            for (int i = 0; i < EVT_N; i++)
                if (core_evt[i] !== m_evt[i]) nt[i] = core_evt[i];
            if (vbus_valid !== m_vb) nt[15] = 1'b1;
            if (id_status  !== m_id) nt[14] = 1'b1;
            nt[9]  = (ep_l[15:0] != 0);
            nt[8]  = (ep_l[31:16] != 0);
            nt[24] = (dma_l != 0);
            m_src[0] = nt;
            m_evt = core_evt; m_vb = vbus_valid; m_id = id_status;
            m_pin = npin;
            if (power_on && !m_pwr) begin
                m_gate = 0; m_run = 1; m_cnt = WAIT;
            end else if (m_run) begin
                if (!power_on) m_run = 0;
                else if (m_cnt == 1) begin m_gate = 1; m_run = 0; end
                else m_cnt = m_cnt - 1;
            end
            m_pwr = power_on;
        end
    end

    function automatic logic [31:0] m_read(logic [3:0] a);
        int g, f;
        g = int'(a[3:2]); f = int'(a[1:0]);
        if (g == 3) return (f == 0) ? m_cfg : 32'h0;
        return (f == 3) ? m_msk[g] : m_src[g];
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cmp_en) begin
            check({31'b0, irq_pin}, {31'b0, m_pin}, {phase, " pin"});
            check(bus_rdata, m_read(bus_addr), {phase, " rdata"});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        #1 check(bus_rdata, exp, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1;
        // R3 reset state
        phase = "R3";
        rd(4'd3,  32'hFFFF_FFFF, "R3 top mask");
        rd(4'd0,  32'h0, "R3 top source");
        rd(4'd7,  32'h0, "R3 endpoint mask");
        check({31'b0, irq_pin}, 32'h0, "R3 pin");
        // R8 power gate
        phase = "R8";
        @(negedge clk); power_on = 1'b1;
        wr(4'd12, 32'h0002_0000);
        wr(4'd3, 32'h0);
        wr(4'd1, 32'h0000_0008);
        idle(4);
        #1 check({31'b0, irq_pin}, 32'h0, "R8 pin held while gate closed");
        idle(WAIT);
        #1 check({31'b0, irq_pin}, 32'h1, "R8 pin after gate opens");
        // R6 / R7 polarity
        phase = "R6";
        wr(4'd2, 32'h0000_0008);
        idle(3);
        #1 check({31'b0, irq_pin}, 32'h0, "R6 nothing pending");
        phase = "R7";
        wr(4'd12, 32'h0);
        idle(3);
        #1 check({31'b0, irq_pin}, 32'h1, "R7 idle-high");
        wr(4'd1, 32'h0000_0020);
        idle(3);
        #1 check({31'b0, irq_pin}, 32'h0, "R7 pending drives low");
        wr(4'd2, 32'h0000_0020);
        wr(4'd12, 32'h0002_0000);
        // R1 / R2 endpoint group
        phase = "R1";
        wr(4'd5, 32'h0001_0003);
        rd(4'd4, 32'h0001_0003, "R2 endpoint via source");
        rd(4'd5, 32'h0001_0003, "R2 endpoint via set");
        rd(4'd6, 32'h0001_0003, "R2 endpoint via clear");
        wr(4'd6, 32'h0000_0001);
        rd(4'd4, 32'h0001_0002, "R1 endpoint after clear");
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, 32'h0001_0002, "R1 source write ignored");
        // R4 summaries
        phase = "R4";
        rd(4'd0, 32'h0000_0300, "R4 tx and rx summary");
        wr(4'd7, 32'h0000_FFFF);
        rd(4'd0, 32'h0000_0100, "R4 tx masked");
        wr(4'd2, 32'h0000_0100);
        rd(4'd0, 32'h0000_0100, "R4 clear of summary ignored");
        rd(4'd7, 32'h0000_FFFF, "R2 mask readback");
        // R5 DMA summary
        phase = "R5";
        wr(4'd9, 32'h0000_0001);
        rd(4'd0, 32'h0100_0100, "R5 dma summary set");
        wr(4'd11, 32'h0000_0001);
        rd(4'd0, 32'h0000_0100, "R5 dma summary masked");
        rd(4'd13, 32'h0, "R2 unused config address");
        // R10 events
        phase = "R10";
        @(negedge clk); core_evt[2] = 1'b1;
        rd(4'd0, 32'h0000_0104, "R10 event raises bit");
        @(negedge clk); core_evt[2] = 1'b0;
        rd(4'd0, 32'h0000_0100, "R10 event falls");
        @(negedge clk);
        core_evt[4] = 1'b1;
        bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h0000_0010;
        @(negedge clk); bus_wr = 1'b0;
        rd(4'd0, 32'h0000_0110, "R10 event beats clear");
        // R11 VBUS / ID
        phase = "R11";
        @(negedge clk); vbus_valid = 1'b1;
        rd(4'd0, 32'h0000_8110, "R11 vbus change");
        wr(4'd2, 32'h0000_8000);
        rd(4'd0, 32'h0000_0110, "R11 vbus cleared");
        @(negedge clk); id_status = 1'b1;
        rd(4'd0, 32'h0000_4110, "R11 id change");
        // R9 power drop mid-wait
        phase = "R9";
        @(negedge clk); power_on = 1'b0;
        idle(2);
        @(negedge clk); power_on = 1'b1;
        idle(5);
        @(negedge clk); power_on = 1'b0;
        idle(WAIT + 5);
        #1 check({31'b0, irq_pin}, 32'h0, "R9 gate stays closed");
        phase = "R8";
        @(negedge clk); power_on = 1'b1;
        idle(WAIT + 3);
        #1 check({31'b0, irq_pin}, 32'h1, "R8 reopens after full wait");
        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5 * 20000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule